// File: doc/BRIEF.md
# 33-bit Rotate and Xor-Shift Random Word Generator

This block produces a stream of 32-bit pseudo-random words from a 33-bit state. The state is a 32-bit word plus one extra bit. Each accepted step does three things to the state. It rotates all 33 bits right by one place. It folds in a left-shifted copy of the old word. It then folds in a right-shifted copy of that intermediate result. The word and the extra bit are driven straight from the state registers. A one-cycle valid flag marks each fresh word.

A client raises the step strobe for every word it wants. The state advances once in each cycle in which the strobe is high, so back-to-back strobes give one new word per cycle. A seed port can overwrite the whole 33-bit state at any time. The block comes out of reset with a fixed non-zero state.

Top module: `prng33_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `rand_o` reads 0x55555555, `hi_o` reads 1 and `valid_o` reads 0.
- R2: After a step, `hi_o` equals bit 0 of the word that `rand_o` showed before the step.
- R3: After a step, let L be the old word and H the old extra bit. Form T = {H, L[31:1]}, then U = T xor (L << 12). The new `rand_o` equals U xor (U >> 20). Both shifts fill with zeros.
- R4: In a cycle with neither step nor seed load, `rand_o` and `hi_o` keep their values.
- R5: `valid_o` is 1 exactly in the cycle after an accepted step, and 0 in every other cycle.
- R6: A seed load makes `rand_o` equal `seed_i[31:0]` and `hi_o` equal `seed_i[32]` in the next cycle.
- R7: When a seed load and a step arrive in the same cycle, the seed wins. No step is taken and `valid_o` stays 0.
- R8: Steps taken back to back, one per cycle, follow the R3 sequence with no word skipped or repeated. This holds for 1000 words from the reset state and for 1000 words from a loaded seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Advance the state once in this cycle |
| seed_load_i | input | 1 | Overwrite the state with `seed_i` |
| seed_i | input | 33 | Seed value: bit 32 is the extra bit, bits 31..0 are the word |
| rand_o | output | 32 | Current 32-bit word of the state |
| hi_o | output | 1 | Current extra state bit |
| valid_o | output | 1 | Pulses for one cycle after each step |

## Verification
The whole state is visible on `rand_o` and `hi_o`, so any corruption shows up at the ports in the cycle after it happens. A mistake in the rotate, the shift amounts or the fill shows up on the first word that differs from the reference. The reference is checked at every step across long runs. A state that moves while idle, or that drops or doubles a step, breaks the word-by-word match or the stable check within one cycle.

// File: rtl/prng33_pkg.sv
package prng33_pkg;
  localparam int unsigned DEF_W      = 32;
  localparam int unsigned DEF_SHL    = 12;
  localparam int unsigned DEF_SHR    = 20;
  localparam logic [31:0] DEF_LO_RST = 32'h5555_5555;
  localparam logic        DEF_HI_RST = 1'b1;

  typedef enum logic {
    SH_LEFT  = 1'b0,
    SH_RIGHT = 1'b1
  } shdir_e;
endpackage

// File: rtl/prng33_rotate.sv
module prng33_rotate #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lo_i,
  input  logic         hi_i,
  output logic [W-1:0] rot_o,
  output logic         out_bit_o
);
  // one-place right rotation of the {hi, lo} register
  always_comb begin
    rot_o     = {hi_i, lo_i[W-1:1]};
    out_bit_o = lo_i[0];
  end
endmodule

// File: rtl/prng33_xorshift.sv
module prng33_xorshift #(
  parameter int unsigned     W     = 32,
  parameter int unsigned     SHIFT = 12,
  parameter prng33_pkg::shdir_e DIR = prng33_pkg::SH_LEFT
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] mix_o
);
  generate
    if (DIR == prng33_pkg::SH_LEFT) begin : g_left
      always_comb mix_o = base_i ^ (src_i << SHIFT);
    end else begin : g_right
      always_comb mix_o = base_i ^ (src_i >> SHIFT);
    end
  endgenerate
endmodule

// File: rtl/prng33_state.sv
module prng33_state #(
  parameter int unsigned W      = 32,
  parameter logic [W-1:0] LO_RST = '0,
  parameter logic         HI_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic         seed_load_i,
  input  logic [W:0]   seed_i,
  input  logic [W-1:0] next_lo_i,
  input  logic         next_hi_i,
  output logic [W-1:0] lo_q,
  output logic         hi_q,
  output logic         valid_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= LO_RST;
      hi_q    <= HI_RST;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (seed_load_i) begin
        lo_q <= seed_i[W-1:0];
        hi_q <= seed_i[W];
      end else if (step_i) begin
        lo_q    <= next_lo_i;
        hi_q    <= next_hi_i;
        valid_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/prng33_gen.sv
module prng33_gen #(
  parameter int unsigned  W      = prng33_pkg::DEF_W,
  parameter int unsigned  SHL    = prng33_pkg::DEF_SHL,
  parameter int unsigned  SHR    = prng33_pkg::DEF_SHR,
  parameter logic [W-1:0] LO_RST = W'(prng33_pkg::DEF_LO_RST),
  parameter logic         HI_RST = prng33_pkg::DEF_HI_RST
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_i,
  input  logic         seed_load_i,
  input  logic [W:0]   seed_i,
  output logic [W-1:0] rand_o,
  output logic         hi_o,
  output logic         valid_o
);
  localparam int unsigned STATE_W = W + 1;

  logic [W-1:0] lo_q, rot_w, mix1_w, mix2_w;
  logic         hi_q, valid_q, shout_w;
  logic [STATE_W-1:0] next_state_w;

  prng33_rotate #(.W(W)) u_rot (
    .lo_i(lo_q), .hi_i(hi_q), .rot_o(rot_w), .out_bit_o(shout_w)
  );

  prng33_xorshift #(.W(W), .SHIFT(SHL), .DIR(prng33_pkg::SH_LEFT)) u_mix1 (
    .base_i(rot_w), .src_i(lo_q), .mix_o(mix1_w)
  );

  prng33_xorshift #(.W(W), .SHIFT(SHR), .DIR(prng33_pkg::SH_RIGHT)) u_mix2 (
    .base_i(mix1_w), .src_i(mix1_w), .mix_o(mix2_w)
  );

  assign next_state_w = {shout_w, mix2_w};

  prng33_state #(.W(W), .LO_RST(LO_RST), .HI_RST(HI_RST)) u_state (
    .clk(clk), .rst(rst), .step_i(step_i), .seed_load_i(seed_load_i),
    .seed_i(seed_i), .next_lo_i(next_state_w[W-1:0]),
    .next_hi_i(next_state_w[STATE_W-1]),
    .lo_q(lo_q), .hi_q(hi_q), .valid_q(valid_q)
  );

  assign rand_o  = lo_q;
  assign hi_o    = hi_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/prng33_chk.sv
module prng33_chk #(
  parameter int unsigned W   = 32,
  parameter int unsigned SHL = 12,
  parameter int unsigned SHR = 20
) (
  input logic         clk,
  input logic         rst,
  input logic         step_i,
  input logic         seed_load_i,
  input logic [W:0]   seed_i,
  input logic [W-1:0] rand_o,
  input logic         hi_o,
  input logic         valid_o
);
  function automatic logic [W-1:0] exp_word(input logic [W-1:0] l, input logic h);
    logic [W-1:0] u;
    u = {h, l[W-1:1]} ^ (l << SHL);
    return u ^ (u >> SHR);
  endfunction

  assert_hi_from_lsb_R2: assert property (@(posedge clk) disable iff (rst)
    (step_i && !seed_load_i) |=> (hi_o == $past(rand_o[0])));

  assert_word_update_R3: assert property (@(posedge clk) disable iff (rst)
    (step_i && !seed_load_i) |=> (rand_o == exp_word($past(rand_o), $past(hi_o))));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!step_i && !seed_load_i) |=> ($stable(rand_o) && $stable(hi_o)));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (step_i && !seed_load_i) |=> valid_o);

  assert_valid_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !(step_i && !seed_load_i) |=> !valid_o);

  assert_seed_load_R6: assert property (@(posedge clk) disable iff (rst)
    seed_load_i |=> ({hi_o, rand_o} == $past(seed_i)));

  assert_seed_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (seed_load_i && step_i) |=> !valid_o);
endmodule

bind prng33_gen prng33_chk #(.W(W), .SHL(SHL), .SHR(SHR)) u_chk (
  .clk(clk), .rst(rst), .step_i(step_i), .seed_load_i(seed_load_i),
  .seed_i(seed_i), .rand_o(rand_o), .hi_o(hi_o), .valid_o(valid_o)
);

// File: tb/sim_prng33_gen.sv
`timescale 1ns/1ps
module sim_prng33_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step_i = 1'b0;
  logic        seed_load_i = 1'b0;
  logic [32:0] seed_i = '0;
  logic [31:0] rand_o;
  logic        hi_o, valid_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic [31:0] m_lo;
  logic        m_hi;

  always #2.5 clk = ~clk;

  prng33_gen u0 (
    .clk(clk), .rst(rst), .step_i(step_i), .seed_load_i(seed_load_i),
    .seed_i(seed_i), .rand_o(rand_o), .hi_o(hi_o), .valid_o(valid_o)
  );

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference step per R2/R3
  task automatic model_step();
    logic [31:0] t, u;
    t = {m_hi, m_lo[31:1]};
    u = t ^ {m_lo[19:0], 12'b0};
    m_hi = m_lo[0];
    m_lo = u ^ {20'b0, u[31:20]};
  endtask

  task automatic cyc(input logic st, input logic sl, input logic [32:0] sv);
    @(negedge clk);
    step_i = st; seed_load_i = sl; seed_i = sv;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; step_i = 0; seed_load_i = 0;
    @(posedge clk); #1;
    chk("R1 in reset", {hi_o, rand_o}, {1'b1, 32'h5555_5555});
    chk("R1 valid in reset", {32'b0, valid_o}, 33'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after reset", {hi_o, rand_o}, {1'b1, 32'h5555_5555});
    chk("R1 valid after reset", {32'b0, valid_o}, 33'd0);
    m_lo = 32'h5555_5555; m_hi = 1'b1;
  endtask

  task automatic t_run(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] old_lo;
      old_lo = m_lo;
      cyc(1'b1, 1'b0, '0);
      model_step();
      chk({tag, " R8 word R3"}, {1'b0, rand_o}, {1'b0, m_lo});
      chk({tag, " R2 high bit"}, {32'b0, hi_o}, {32'b0, old_lo[0]});
      chk({tag, " R5 valid"}, {32'b0, valid_o}, 33'd1);
    end
  endtask

  task automatic t_hold();
    for (int i = 0; i < 5; i++) begin
      cyc(1'b0, 1'b0, '0);
      chk("R4 idle hold", {hi_o, rand_o}, {m_hi, m_lo});
      chk("R5 valid low idle", {32'b0, valid_o}, 33'd0);
    end
  endtask

  task automatic t_seed(input logic [32:0] s);
    cyc(1'b0, 1'b1, s);
    m_hi = s[32]; m_lo = s[31:0];
    chk("R6 seed load", {hi_o, rand_o}, s);
    chk("R6 valid low", {32'b0, valid_o}, 33'd0);
  endtask

  task automatic t_priority(input logic [32:0] s);
    cyc(1'b1, 1'b1, s);
    m_hi = s[32]; m_lo = s[31:0];
    chk("R7 seed beats step", {hi_o, rand_o}, s);
    chk("R7 no valid", {32'b0, valid_o}, 33'd0);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b0, '0);
      model_step();
      chk("R3 gapped step", {hi_o, rand_o}, {m_hi, m_lo});
      cyc(1'b0, 1'b0, '0);
      chk("R5 valid one cycle", {32'b0, valid_o}, 33'd0);
      chk("R4 hold between", {hi_o, rand_o}, {m_hi, m_lo});
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_hold();
    t_run("reset-run", 1000);
    t_hold();
    t_seed({1'b0, 32'hDEAD_BEEF});
    t_run("seed-run", 1000);
    t_seed({1'b1, 32'h0000_0001});
    t_run("edge-seed", 4);
    t_priority({1'b1, 32'h1234_5678});
    t_hold();
    t_gaps();
    t_reset();
    t_run("re-reset", 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule